// File: doc/BRIEF.md
# Serial Frame Timing Calculator

This block turns the line-format settings and the baud divisor of a UART into a published frame description (data width, stop bits, parity) and the length of one character in clock ticks. The baud rate is a 115200 reference divided by the divisor. The bit time is the tick rate divided by that baud rate. The character time is the bit time multiplied by the frame size. The frame size counts the data bits, the stop bits and the optional parity bit.

The same block holds the modem control byte. When the modem control outputs change and loopback is not selected, the block drives the request-to-send and data-terminal-ready lines from the new value. It then runs a one-shot delay of one character time and ends it with a pulse. A surrounding controller uses that pulse to resample the modem status lines. A divisor of zero is treated as "not configured": it leaves every published value as it was.

Top module: `line_char_timer`

## Requirements
- R1: After reset the block publishes 8 data bits, one stop bit and no parity, and a character time of (TICK_HZ / 9600) * 9 ticks (1728 with defaults). The modem control value reads 0x08, rts_out and dtr_out are 0, and calc_busy, delay_active and resample_pulse are 0.
- R2: The published data width is lcr_wdata[1:0] + 5, giving 5 to 8 bits.
- R3: lcr_wdata[2] selects two stop bits (otherwise one). lcr_wdata[3] enables parity. With parity enabled, lcr_wdata[4] selects even parity (otherwise odd).
- R4: char_ticks = (TICK_HZ / (115200 / divisor)) * (data bits + stop bits + parity bit). Both divisions truncate.
- R5: A write that leaves the divisor non-zero raises calc_busy from the next cycle. The frame fields and char_ticks change only on the cycle calc_busy falls. A new write during the computation restarts it, so only the last setting is published.
- R6: With the divisor at zero no computation starts and all published values hold. Format writes made meanwhile are kept and take effect when a non-zero divisor is written.
- R7: A modem control write stores mcr_wdata[4:0], readable on mcr_q from the next cycle.
- R8: A modem control write with bit 4 (loopback) set leaves rts_out and dtr_out unchanged and starts no delay.
- R9: A modem control write outside loopback whose value differs from the stored one sets rts_out from bit 1 and dtr_out from bit 0, and starts the delay. A write of an equal value has no effect on the lines or the delay.
- R10: resample_pulse is high for exactly one cycle, char_ticks cycles after the edge that accepted the starting write. delay_active is high in between.
- R11: A new change while the delay runs restarts it from the full character time, with no pulse for the earlier change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lcr_we | input | 1 | Line format write strobe |
| lcr_wdata | input | 5 | Line format value |
| div_we | input | 1 | Divisor write strobe |
| div_wdata | input | DIV_W | Divisor value |
| mcr_we | input | 1 | Modem control write strobe |
| mcr_wdata | input | 5 | Modem control value |
| data_bits | output | 4 | Published data width |
| two_stop | output | 1 | Published two-stop-bit flag |
| parity_en | output | 1 | Published parity enable |
| parity_even | output | 1 | Published even parity select |
| char_ticks | output | CT_W | Published character time in ticks |
| calc_busy | output | 1 | Computation in progress |
| mcr_q | output | 5 | Stored modem control value |
| rts_out | output | 1 | Request-to-send line |
| dtr_out | output | 1 | Data-terminal-ready line |
| delay_active | output | 1 | Character delay running |
| resample_pulse | output | 1 | End of the character delay |

## Verification
The bench targets divisors whose reference division does not come out exact (7, and 65535 where the baud rate drops to 1). A design that rounded, or that multiplied before dividing, would publish a different tick count. It writes a zero divisor and then a new format. A design that computed anyway would divide by zero or publish early. It overlaps two writes, which a design without restart would show as two results or a stale one. On the modem side it covers repeated equal writes, loopback writes and a change during a running delay. A wrong design there would toggle the lines, pulse spuriously, or pulse measured from the first write instead of the last.

// File: rtl/lcct_pkg.sv
package lcct_pkg;

    typedef struct packed {
        logic [3:0] data_bits;
        logic       two_stop;
        logic       par_en;
        logic       par_even;
    } frame_fmt_t;

    typedef enum logic [1:0] {
        C_IDLE = 2'd0,
        C_BAUD = 2'd1,
        C_BIT  = 2'd2
    } calc_state_t;

    localparam frame_fmt_t RESET_FMT = '{data_bits: 4'd8, two_stop: 1'b0,
                                         par_en: 1'b0, par_even: 1'b0};
    localparam int RESET_DIV = 12;
    localparam logic [4:0] RESET_MCR = 5'h08;

    function automatic frame_fmt_t decode_fmt(input logic [4:0] v);
        frame_fmt_t f;
        f.data_bits = 4'(v[1:0]) + 4'd5;
        f.two_stop  = v[2];
        f.par_en    = v[3];
        f.par_even  = v[3] & v[4];
        return f;
    endfunction

    function automatic logic [3:0] frame_len(input frame_fmt_t f);
        return f.data_bits + 4'(f.two_stop) + 4'd1 + 4'(f.par_en);
    endfunction

endpackage

// File: rtl/lcct_div.sv
module lcct_div #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q, quo_q, dvs_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [W:0]    shifted;
    logic [W-1:0]  diff, rem_n, quo_n;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        diff    = shifted[W-1:0] - dvs_q;
        if (shifted >= {1'b0, dvs_q}) begin
            rem_n = diff;
            quo_n = {quo_q[W-2:0], 1'b1};
        end else begin
            rem_n = shifted[W-1:0];
            quo_n = {quo_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q <= '0;
                quo_q <= dividend;
                dvs_q <= divisor;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= rem_n;
                quo_q <= quo_n;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;
endmodule

// File: rtl/lcct_calc.sv
module lcct_calc
    import lcct_pkg::*;
#(
    parameter int TICK_HZ = 1843200,
    parameter int REF_HZ  = 115200,
    parameter int DIV_W   = 16,
    parameter int QW      = 24,
    parameter int CT_W    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lcr_we,
    input  logic [4:0]       lcr_wdata,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    output frame_fmt_t       fmt_pub,
    output logic [CT_W-1:0]  ticks_pub,
    output logic             busy
);
    localparam int RESET_TICKS = (TICK_HZ / (REF_HZ / RESET_DIV)) * 9;

    calc_state_t      state_q;
    logic [DIV_W-1:0] div_q, div_n;
    logic [4:0]       lcr_q, lcr_n;
    frame_fmt_t       pend_q;
    logic             trig;
    logic             dv_start, dv_done;
    logic [QW-1:0]    dv_dividend, dv_divisor, dv_quo;

    assign div_n = div_we ? div_wdata : div_q;
    assign lcr_n = lcr_we ? lcr_wdata : lcr_q;
    assign trig  = (div_we || lcr_we) && (div_n != '0);

    always_comb begin
        dv_start    = 1'b0;
        dv_dividend = QW'(REF_HZ);
        dv_divisor  = QW'(div_n);
        if (trig) begin
            dv_start = 1'b1;
        end else if (state_q == C_BAUD && dv_done) begin
            dv_start    = 1'b1;
            dv_dividend = QW'(TICK_HZ);
            dv_divisor  = dv_quo;
        end
    end

    lcct_div #(.W(QW)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (dv_start),
        .dividend (dv_dividend),
        .divisor  (dv_divisor),
        .done     (dv_done),
        .quotient (dv_quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= C_IDLE;
            div_q     <= DIV_W'(RESET_DIV);
            lcr_q     <= 5'h03;
            pend_q    <= RESET_FMT;
            fmt_pub   <= RESET_FMT;
            ticks_pub <= CT_W'(RESET_TICKS);
        end else begin
            div_q <= div_n;
            lcr_q <= lcr_n;
            if (trig) begin
                pend_q  <= decode_fmt(lcr_n);
                state_q <= C_BAUD;
            end else begin
                case (state_q)
                    C_BAUD: if (dv_done) state_q <= C_BIT;
                    C_BIT: if (dv_done) begin
                        ticks_pub <= CT_W'(dv_quo) * CT_W'(frame_len(pend_q));
                        fmt_pub   <= pend_q;
                        state_q   <= C_IDLE;
                    end
                    default: state_q <= C_IDLE;
                endcase
            end
        end
    end

    assign busy = (state_q != C_IDLE);
endmodule

// File: rtl/lcct_mdelay.sv
module lcct_mdelay
    import lcct_pkg::*;
#(
    parameter int CT_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mcr_we,
    input  logic [4:0]      mcr_wdata,
    input  logic [CT_W-1:0] char_ticks,
    output logic [4:0]      mcr_q,
    output logic            rts,
    output logic            dtr,
    output logic            active,
    output logic            pulse
);
    logic [CT_W-1:0] cnt_q;
    logic            start;

    assign start  = mcr_we && !mcr_wdata[4] && (mcr_wdata != mcr_q);
    assign active = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            mcr_q <= RESET_MCR;
            rts   <= 1'b0;
            dtr   <= 1'b0;
            cnt_q <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (mcr_we) mcr_q <= mcr_wdata;
            if (start) begin
                rts   <= mcr_wdata[1];
                dtr   <= mcr_wdata[0];
                cnt_q <= char_ticks;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CT_W'(1)) pulse <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/line_char_timer.sv
module line_char_timer
    import lcct_pkg::*;
#(
    parameter int TICK_HZ = 1843200,
    parameter int REF_HZ  = 115200,
    parameter int DIV_W   = 16,
    parameter int QW      = 24,
    parameter int CT_W    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lcr_we,
    input  logic [4:0]       lcr_wdata,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             mcr_we,
    input  logic [4:0]       mcr_wdata,
    output logic [3:0]       data_bits,
    output logic             two_stop,
    output logic             parity_en,
    output logic             parity_even,
    output logic [CT_W-1:0]  char_ticks,
    output logic             calc_busy,
    output logic [4:0]       mcr_q,
    output logic             rts_out,
    output logic             dtr_out,
    output logic             delay_active,
    output logic             resample_pulse
);
    frame_fmt_t fmt;

    lcct_calc #(
        .TICK_HZ(TICK_HZ), .REF_HZ(REF_HZ), .DIV_W(DIV_W), .QW(QW), .CT_W(CT_W)
    ) u_calc (
        .clk       (clk),
        .rst       (rst),
        .lcr_we    (lcr_we),
        .lcr_wdata (lcr_wdata),
        .div_we    (div_we),
        .div_wdata (div_wdata),
        .fmt_pub   (fmt),
        .ticks_pub (char_ticks),
        .busy      (calc_busy)
    );

    lcct_mdelay #(.CT_W(CT_W)) u_mdelay (
        .clk        (clk),
        .rst        (rst),
        .mcr_we     (mcr_we),
        .mcr_wdata  (mcr_wdata),
        .char_ticks (char_ticks),
        .mcr_q      (mcr_q),
        .rts        (rts_out),
        .dtr        (dtr_out),
        .active     (delay_active),
        .pulse      (resample_pulse)
    );

    assign data_bits   = fmt.data_bits;
    assign two_stop    = fmt.two_stop;
    assign parity_en   = fmt.par_en;
    assign parity_even = fmt.par_even;
endmodule

// File: rtl/lcct_chk.sv
module lcct_chk #(
    parameter int DIV_W = 16,
    parameter int CT_W  = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             lcr_we,
    input logic             div_we,
    input logic [DIV_W-1:0] div_wdata,
    input logic             mcr_we,
    input logic [4:0]       mcr_wdata,
    input logic [3:0]       data_bits,
    input logic [CT_W-1:0]  char_ticks,
    input logic             calc_busy,
    input logic [4:0]       mcr_q,
    input logic             rts_out,
    input logic             dtr_out,
    input logic             delay_active,
    input logic             resample_pulse
);
    // R5
    ticks_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(char_ticks) |-> $past(calc_busy));

    // R5
    width_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_bits) |-> $past(calc_busy));

    // R6
    zero_div_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (div_we && div_wdata == '0 && !lcr_we && !calc_busy) |=> !calc_busy);

    // R7
    mcr_store_chk: assert property (@(posedge clk) disable iff (rst)
        mcr_we |=> mcr_q == $past(mcr_wdata));

    // R8
    loop_lines_chk: assert property (@(posedge clk) disable iff (rst)
        (mcr_we && mcr_wdata[4]) |=> ($stable(rts_out) && $stable(dtr_out)));

    // R10
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        resample_pulse |=> !resample_pulse);

    // R10
    pulse_source_chk: assert property (@(posedge clk) disable iff (rst)
        resample_pulse |-> ($past(delay_active) && !delay_active));
endmodule

bind line_char_timer lcct_chk #(.DIV_W(DIV_W), .CT_W(CT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .lcr_we         (lcr_we),
    .div_we         (div_we),
    .div_wdata      (div_wdata),
    .mcr_we         (mcr_we),
    .mcr_wdata      (mcr_wdata),
    .data_bits      (data_bits),
    .char_ticks     (char_ticks),
    .calc_busy      (calc_busy),
    .mcr_q          (mcr_q),
    .rts_out        (rts_out),
    .dtr_out        (dtr_out),
    .delay_active   (delay_active),
    .resample_pulse (resample_pulse)
);

// File: tb/line_char_timer_tb.sv
module line_char_timer_tb;
    localparam int TICK = 1843200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lcr_we = 1'b0, div_we = 1'b0, mcr_we = 1'b0;
    logic [4:0]  lcr_wdata = '0, mcr_wdata = '0;
    logic [15:0] div_wdata = '0;
    logic [3:0]  data_bits;
    logic        two_stop, parity_en, parity_even;
    logic [31:0] char_ticks;
    logic        calc_busy, rts_out, dtr_out, delay_active, resample_pulse;
    logic [4:0]  mcr_q;

    int checks = 0, failures = 0, pulses = 0;
    bit finished = 0;

    typedef struct {
        longint ticks;
        int     dbits;
        int     two;
        int     pe;
        int     pev;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    line_char_timer u_dut (
        .clk(clk), .rst(rst),
        .lcr_we(lcr_we), .lcr_wdata(lcr_wdata),
        .div_we(div_we), .div_wdata(div_wdata),
        .mcr_we(mcr_we), .mcr_wdata(mcr_wdata),
        .data_bits(data_bits), .two_stop(two_stop), .parity_en(parity_en),
        .parity_even(parity_even), .char_ticks(char_ticks), .calc_busy(calc_busy),
        .mcr_q(mcr_q), .rts_out(rts_out), .dtr_out(dtr_out),
        .delay_active(delay_active), .resample_pulse(resample_pulse)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic exp_t model(input int lcr, input int dv);
        exp_t e;
        int baud, bitt;
        baud    = 115200 / dv;
        bitt    = TICK / baud;
        e.dbits = (lcr & 3) + 5;
        e.two   = (lcr >> 2) & 1;
        e.pe    = (lcr >> 3) & 1;
        e.pev   = e.pe & ((lcr >> 4) & 1);
        e.ticks = longint'(bitt) * (e.dbits + e.two + 1 + e.pe);
        return e;
    endfunction

    task automatic check_pub(input string req, input exp_t e);
        check({req, " char_ticks"}, char_ticks, e.ticks);
        check({req, " data_bits"}, data_bits, e.dbits);
        check({req, " two_stop"}, two_stop, e.two);
        check({req, " parity_en"}, parity_en, e.pe);
        check({req, " parity_even"}, parity_even, e.pev);
    endtask

    // Scoreboard monitor: compare published values on each fall of busy
    bit prev_busy = 0;
    always @(negedge clk) begin
        if (rst) prev_busy = 0;
        else begin
            if (prev_busy && !calc_busy) begin
                if (sb.size() == 0) check("R5 unexpected result", 1, 0);
                else check_pub("R4 scoreboard", sb.pop_front());
            end
            prev_busy = calc_busy;
            if (resample_pulse) pulses++;
        end
    end

    // Driver: one configuration write, expected item pushed
    task automatic cfg(input bit wl, input int lcr, input bit wd, input int dv,
                       input int eff_lcr, input int eff_div, input bit push);
        lcr_we = wl; lcr_wdata = 5'(lcr);
        div_we = wd; div_wdata = 16'(dv);
        @(negedge clk);
        lcr_we = 0; div_we = 0;
        if (push) begin
            check("R5 busy after write", calc_busy, 1);
            sb.push_back(model(eff_lcr, eff_div));
        end
    endtask

    task automatic wait_idle();
        while (calc_busy) @(negedge clk);
        @(negedge clk);
        check("R5 scoreboard drained", sb.size(), 0);
    endtask

    task automatic mcr_wr(input int v);
        mcr_we = 1; mcr_wdata = 5'(v);
        @(negedge clk);
        mcr_we = 0;
    endtask

    task automatic count_pulse(output int n);
        n = 0;
        while (!resample_pulse && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n, p0;
        exp_t e;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check_pub("R1", model(3, 12));
        check("R1 char_ticks 1728", char_ticks, 1728);
        check("R1 mcr_q", mcr_q, 8);
        check("R1 rts", rts_out, 0);
        check("R1 dtr", dtr_out, 0);
        check("R1 busy", calc_busy, 0);
        check("R1 delay", delay_active, 0);
        check("R1 pulse", resample_pulse, 0);

        // R2 R3 R4 assorted formats and divisors
        cfg(1, 5'h1F, 1, 1, 5'h1F, 1, 1); wait_idle();       // 8 data, 2 stop, even
        cfg(1, 5'h0E, 1, 3, 5'h0E, 3, 1); wait_idle();       // 7 data, 2 stop, odd
        cfg(1, 5'h01, 1, 7, 5'h01, 7, 1); wait_idle();       // truncating divisions
        cfg(1, 5'h03, 1, 65535, 5'h03, 65535, 1); wait_idle(); // baud of 1
        cfg(1, 5'h00, 1, 1, 5'h00, 1, 1); wait_idle();       // R2 5 data bits
        check("R4 fast config 96", char_ticks, 96);

        // R5 restart: second write during busy, only last applied
        cfg(1, 5'h0B, 1, 4, 5'h0B, 4, 0);
        repeat (5) @(negedge clk);
        cfg(0, 0, 1, 1, 5'h0B, 1, 1);
        wait_idle();

        // R6 zero divisor freezes everything
        e = model(5'h0B, 1);
        cfg(0, 0, 1, 0, 0, 0, 0);
        repeat (10) @(negedge clk);
        check("R6 no busy on zero div", calc_busy, 0);
        check_pub("R6 frozen", e);
        cfg(1, 5'h07, 0, 0, 0, 0, 0);
        repeat (10) @(negedge clk);
        check("R6 no busy on lcr write", calc_busy, 0);
        check_pub("R6 frozen after lcr", e);
        cfg(0, 0, 1, 2, 5'h07, 2, 1);
        wait_idle();
        check("R6 deferred format 320", char_ticks, 320);

        cfg(1, 5'h00, 1, 1, 5'h00, 1, 1); wait_idle();       // back to 96

        // R7 R9 R10 change outside loopback
        p0 = pulses;
        mcr_wr(5'h03);
        check("R7 mcr_q", mcr_q, 3);
        check("R9 rts", rts_out, 1);
        check("R9 dtr", dtr_out, 1);
        check("R10 delay active", delay_active, 1);
        count_pulse(n);
        check("R10 pulse delay 96", n, 96);
        @(negedge clk);
        check("R10 pulse one cycle", resample_pulse, 0);
        check("R10 delay ended", delay_active, 0);
        check("R10 pulse count", pulses - p0, 1);

        // R9 equal value: no effect
        p0 = pulses;
        mcr_wr(5'h03);
        check("R9 equal no delay", delay_active, 0);
        repeat (120) @(negedge clk);
        check("R9 equal no pulse", pulses - p0, 0);

        // R8 loopback
        mcr_wr(5'h11);
        check("R7 mcr_q loop", mcr_q, 5'h11);
        check("R8 rts held", rts_out, 1);
        check("R8 dtr held", dtr_out, 1);
        check("R8 no delay", delay_active, 0);
        mcr_wr(5'h10);
        check("R8 rts held again", rts_out, 1);
        repeat (120) @(negedge clk);
        check("R8 no pulse", pulses - p0, 0);

        // R11 restart while running
        mcr_wr(5'h01);
        check("R9 rts from bit1", rts_out, 0);
        check("R9 dtr from bit0", dtr_out, 1);
        repeat (40) @(negedge clk);
        mcr_wr(5'h02);
        check("R11 rts", rts_out, 1);
        check("R11 dtr", dtr_out, 0);
        count_pulse(n);
        check("R11 restart full delay", n, 96);
        repeat (3) @(negedge clk);
        check("R11 single pulse", pulses - p0, 1);

        // R10 with another character time
        cfg(1, 5'h1F, 1, 1, 5'h1F, 1, 1); wait_idle();
        mcr_wr(5'h00);
        count_pulse(n);
        check("R10 pulse delay 176", n, 176);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule